// File: doc/BRIEF.md
# Command Packet Receiver and Validator

This block sits behind a link deserializer and turns a stream of 32-bit words into checked command packets. It hunts for a two-word preamble, reads a header word, stores the payload in a local buffer and compares the trailing checksum word against a CRC-32 that it computes over the header and payload as they arrive. A good command addressed to this card, or to every card, is offered on an execution port. The executing logic reads the payload through a random-access read port and accepts the command with a valid/ready handshake.

A packet whose header holds an unknown command code or an oversized length, or whose checksum does not match, is thrown away, and the block pulses an error-reply request with a cause code. A word that breaks the preamble means the receiver has lost alignment. It then waits silently for the next preamble, and the lost packet leads to no error request. Packets for another card are dropped silently as well.

Back-pressure: the input stream has no ready signal, because the link cannot be stalled. Only one command is held at a time. While `cmd_valid` is high, every incoming word is discarded and the receiver goes back to hunting for a preamble. `cmd_valid`, `cmd_code`, `cmd_len` and the buffered payload stay stable until the cycle in which `cmd_ready` is sampled high.

Top module: `cmd_pkt_rx`

## Requirements
- R1: In hunt, every word other than 0xA5A5A5A5 is ignored. A packet begins with 0xA5A5A5A5 followed by 0x5A5A5A5A. If the second preamble word is another 0xA5A5A5A5, that word is treated as a new first preamble word. Any other word in that position returns the receiver to hunt. None of this raises `err_req`.
- R2: The word after the preamble is the header: card address in bits [31:24], command code in bits [23:16] and payload length in words in bits [15:0]. Next come exactly that many payload words and then one checksum word.
- R3: The checksum is a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, taken most significant bit first over the header and payload words, with the result inverted. When it matches, `cmd_valid` rises on the clock edge that samples the checksum word. `cmd_code` and `cmd_len` then carry the header fields, and `pay_rd_data` returns payload word i for `pay_rd_addr` = i, in the same cycle.
- R4: When the checksum does not match, no command is offered. `err_req` is high for exactly one cycle after the edge that samples the checksum word, with `err_cause` = 2'b10.
- R5: The known command codes are 0x01 to 0x05, and a length of 0 to 58 is legal. A header addressed to this card with any other code or length is a bad field. `err_req` pulses with `err_cause` = 2'b01 after the edge that samples the header, and the receiver returns to hunt.
- R6: A header whose card address is neither `slot_id` nor 0xFF drops the packet silently. No error is requested, even if the code, length or checksum of that packet is bad.
- R7: Card address 0xFF (broadcast) is accepted in the same way as the own slot address.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_code` and `cmd_len` hold their values. After a cycle with both high, `cmd_valid` is low.
- R9: Words that arrive while a command is held are discarded without raising `err_req`, and the receiver restarts its preamble hunt. A complete packet sent during that time produces no command.
- R10: `err_cause` is 2'b00 whenever `err_req` is low. `err_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Deserialized link word |
| slot_id | input | 8 | Hardwired card address of this slot |
| cmd_valid | output | 1 | Accepted command held for execution |
| cmd_ready | input | 1 | Execution side takes the held command |
| cmd_code | output | 8 | Command code of the held command |
| cmd_len | output | 16 | Payload length in words of the held command |
| pay_rd_addr | input | 6 | Payload word index to read |
| pay_rd_data | output | 32 | Payload word at `pay_rd_addr` (combinational) |
| err_req | output | 1 | One-cycle error-reply request |
| err_cause | output | 2 | 01 bad field, 10 bad checksum, 00 otherwise |

## Verification
The main path is driven with own-slot and broadcast packets of lengths 0, 3 and 58, so that checksum coverage of the header alone and of a full buffer is separated from a short payload. Junk before the preamble, a repeated first preamble word and a broken second word show that resynchronisation is silent and still keeps the next packet. Error packets differ in one property each: a corrupt checksum, a length of 59 and an unknown code, plus a foreign address carrying a bad code and a foreign address carrying a bad checksum. This separates each cause code from the silent address drop. A packet sent while a command is held without ready shows that the held fields stay unchanged and that the interrupted packet disappears.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  localparam logic [31:0] PRE_FIRST  = 32'hA5A5A5A5;
  localparam logic [31:0] PRE_SECOND = 32'h5A5A5A5A;
  localparam logic [7:0]  CARD_ALL   = 8'hFF;
  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_HUNT_A, ST_HUNT_B, ST_HEAD, ST_BODY, ST_SUM
  } rx_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FIELD = 2'b01,
    CAUSE_SUM   = 2'b10
  } err_cause_t;

  typedef enum logic [7:0] {
    OP_WRITE = 8'h01,
    OP_READ  = 8'h02,
    OP_START = 8'h03,
    OP_STOP  = 8'h04,
    OP_RESET = 8'h05
  } op_code_t;

  typedef struct packed {
    logic [7:0]  card;
    logic [7:0]  code;
    logic [15:0] len;
  } head_t;

  function automatic logic known_op(input logic [7:0] c);
    return (c >= OP_WRITE) && (c <= OP_RESET);
  endfunction

  // Feed one 32-bit word into the CRC register, MSB first.
  function automatic logic [31:0] crc_feed(input logic [31:0] c_in,
                                           input logic [31:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int b = 31; b >= 0; b--) begin
      fb = c[31] ^ d[b];
      c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/cmdrx_crc.sv
module cmdrx_crc
  import cmdrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        feed,
  input  logic [31:0] word,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || seed) crc_q <= CRC_SEED;
    else if (feed)      crc_q <= crc_feed(crc_q, word);
  end
endmodule

// File: rtl/cmdrx_head_check.sv
module cmdrx_head_check
  import cmdrx_pkg::*;
#(
  parameter int MAX_LEN = 58
) (
  input  logic [31:0] word,
  input  logic [7:0]  slot_id,
  output logic        mine,
  output logic        fields_ok
);
  head_t h;
  always_comb begin
    h         = head_t'(word);
    mine      = (h.card == slot_id) || (h.card == CARD_ALL);
    fields_ok = known_op(h.code) && (h.len <= 16'(MAX_LEN));
  end
endmodule

// File: rtl/cmdrx_store.sv
module cmdrx_store #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/cmdrx_frame.sv
module cmdrx_frame
  import cmdrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic          mine,
  input  logic          fields_ok,
  input  logic [31:0]   crc_q,
  input  logic          cmd_ready,
  output logic          crc_seed,
  output logic          crc_feed_en,
  output logic          st_we,
  output logic [AW-1:0] st_waddr,
  output logic          cmd_valid,
  output logic [7:0]    cmd_code,
  output logic [15:0]   cmd_len,
  output logic          err_req,
  output logic [1:0]    err_cause
);
  rx_state_t   state;
  head_t       head;
  logic [15:0] idx;
  logic        take;

  assign take = in_valid && !cmd_valid;

  always_comb begin
    crc_seed    = (state == ST_HUNT_A) || (state == ST_HUNT_B);
    crc_feed_en = take && ((state == ST_HEAD) || (state == ST_BODY));
    st_we       = take && (state == ST_BODY);
    st_waddr    = idx[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT_A;
      head      <= '0;
      idx       <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_len   <= '0;
      err_req   <= 1'b0;
      err_cause <= CAUSE_NONE;
    end else begin
      err_req   <= 1'b0;
      err_cause <= CAUSE_NONE;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (in_valid && cmd_valid) begin
        state <= ST_HUNT_A;
      end else if (in_valid) begin
        unique case (state)
          ST_HUNT_A: if (in_data == PRE_FIRST) state <= ST_HUNT_B;
          ST_HUNT_B: begin
            if (in_data == PRE_SECOND)     state <= ST_HEAD;
            else if (in_data != PRE_FIRST) state <= ST_HUNT_A;
          end
          ST_HEAD: begin
            idx <= '0;
            if (!mine) begin
              state <= ST_HUNT_A;
            end else if (!fields_ok) begin
              state     <= ST_HUNT_A;
              err_req   <= 1'b1;
              err_cause <= CAUSE_FIELD;
            end else begin
              head  <= head_t'(in_data);
              state <= (in_data[15:0] == 16'd0) ? ST_SUM : ST_BODY;
            end
          end
          ST_BODY: begin
            idx <= idx + 16'd1;
            if (idx == head.len - 16'd1) state <= ST_SUM;
          end
          ST_SUM: begin
            state <= ST_HUNT_A;
            if (in_data == ~crc_q) begin
              cmd_valid <= 1'b1;
              cmd_code  <= head.code;
              cmd_len   <= head.len;
            end else begin
              err_req   <= 1'b1;
              err_cause <= CAUSE_SUM;
            end
          end
          default: state <= ST_HUNT_A;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
  import cmdrx_pkg::*;
#(
  parameter int MAX_LEN = 58,
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic [7:0]    slot_id,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_code,
  output logic [15:0]   cmd_len,
  input  logic [AW-1:0] pay_rd_addr,
  output logic [31:0]   pay_rd_data,
  output logic          err_req,
  output logic [1:0]    err_cause
);
  logic          mine, fields_ok, crc_seed, crc_feed_en, st_we;
  logic [31:0]   crc_q;
  logic [AW-1:0] st_waddr;

  cmdrx_head_check #(.MAX_LEN(MAX_LEN)) u_head (
    .word(in_data), .slot_id(slot_id), .mine(mine), .fields_ok(fields_ok)
  );

  cmdrx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .seed(crc_seed), .feed(crc_feed_en),
    .word(in_data), .crc_q(crc_q)
  );

  cmdrx_store #(.DEPTH(DEPTH), .WIDTH(32)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(in_data),
    .raddr(pay_rd_addr), .rdata(pay_rd_data)
  );

  cmdrx_frame #(.DEPTH(DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mine(mine), .fields_ok(fields_ok), .crc_q(crc_q),
    .cmd_ready(cmd_ready), .crc_seed(crc_seed), .crc_feed_en(crc_feed_en),
    .st_we(st_we), .st_waddr(st_waddr), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_len(cmd_len), .err_req(err_req),
    .err_cause(err_cause)
  );
endmodule

// File: rtl/cmdrx_props.sv
module cmdrx_props #(
  parameter int MAX_LEN = 58
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_code,
  input logic [15:0] cmd_len,
  input logic        err_req,
  input logic [1:0]  err_cause
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_len)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |=> !err_req);

  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_req |-> (err_cause == 2'b00));

  assert_cause_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> (err_cause == 2'b01 || err_cause == 2'b10));

  assert_len_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len <= 16'(MAX_LEN)));

  assert_code_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code >= 8'h01 && cmd_code <= 8'h05));

  assert_quiet_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !err_req);

  assert_no_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> !$rose(cmd_valid));
endmodule

bind cmd_pkt_rx cmdrx_props #(.MAX_LEN(MAX_LEN)) u_props (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_code(cmd_code), .cmd_len(cmd_len), .err_req(err_req),
  .err_cause(err_cause)
);

// File: tb/sim_cmd_pkt_rx.sv
module sim_cmd_pkt_rx;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SLOT = 8'h07;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, cmd_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic [5:0]  pay_rd_addr = '0;
  logic        cmd_valid, err_req;
  logic [7:0]  cmd_code;
  logic [15:0] cmd_len;
  logic [31:0] pay_rd_data;
  logic [1:0]  err_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_pkt_rx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .slot_id(SLOT), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_len(cmd_len), .pay_rd_addr(pay_rd_addr),
    .pay_rd_data(pay_rd_data), .err_req(err_req), .err_cause(err_cause)
  );

  typedef struct packed {
    logic        is_err;
    logic [1:0]  cause;
    logic [7:0]  code;
    logic [15:0] len;
    logic [31:0] seed;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0, errors = 0;
  bit   cmd_seen = 0, auto_ack = 1, done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pay_word(input logic [31:0] seed, input int i);
    return (seed * 32'h01000193) ^ (32'(i) * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] d);
    logic [31:0] c = c_in;
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ d[b]) c = (c << 1) ^ 32'h04C11DB7;
      else              c = c << 1;
    end
    return c;
  endfunction

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic send_pkt(input logic [7:0] card, input logic [7:0] code,
                          input logic [15:0] len, input logic [31:0] seed,
                          input bit bad_sum);
    logic [31:0] c, hdr;
    hdr = {card, code, len};
    c = crc_step(32'hFFFFFFFF, hdr);
    put(32'hA5A5A5A5);
    put(32'h5A5A5A5A);
    put(hdr);
    for (int i = 0; i < int'(len); i++) begin
      put(pay_word(seed, i));
      c = crc_step(c, pay_word(seed, i));
    end
    put(bad_sum ? (~c ^ 32'h00000100) : ~c);
    stop_in();
  endtask

  task automatic expect_cmd(input logic [7:0] code, input logic [15:0] len,
                            input logic [31:0] seed);
    q.push_back('{is_err: 1'b0, cause: 2'b00, code: code, len: len, seed: seed});
  endtask

  task automatic expect_err(input logic [1:0] cause);
    q.push_back('{is_err: 1'b1, cause: cause, code: 8'h0, len: 16'h0, seed: 32'h0});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares events against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (err_req) begin
        if (q.size() == 0) check(0, "R6", "unexpected err_req cause", 32'(err_cause), 32'h0);
        else begin
          cur = q.pop_front();
          check(cur.is_err, "R3", "error where command expected", 32'(err_cause), 32'h0);
          check(err_cause == cur.cause, (cur.cause == 2'b10) ? "R4" : "R5",
                "err_cause", 32'(err_cause), 32'(cur.cause));
        end
      end
      if (cmd_valid && !cmd_seen) begin
        cmd_seen = 1;
        if (q.size() == 0) check(0, "R9", "unexpected command code", 32'(cmd_code), 32'h0);
        else begin
          cur = q.pop_front();
          check(!cur.is_err, "R4", "command where error expected", 32'(cmd_code), 32'h0);
          check(cmd_code == cur.code, "R3", "cmd_code", 32'(cmd_code), 32'(cur.code));
          check(cmd_len == cur.len, "R3", "cmd_len", 32'(cmd_len), 32'(cur.len));
        end
      end
    end
  end

  // Consumer: reads payload and accepts the held command.
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_seen && auto_ack) begin
        for (int i = 0; i < int'(cur.len); i++) begin
          pay_rd_addr = 6'(i);
          #1;
          check(pay_rd_data == pay_word(cur.seed, i), "R3", "payload word",
                pay_rd_data, pay_word(cur.seed, i));
          @(negedge clk);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check(cmd_valid == 1'b0, "R8", "cmd_valid after handshake", 32'(cmd_valid), 32'h0);
        cmd_seen = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "R1", "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(cmd_valid == 1'b0, "R8", "reset cmd_valid", 32'(cmd_valid), 32'h0);
    check(err_req == 1'b0 && err_cause == 2'b00, "R10", "reset err", 32'(err_cause), 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3: own slot, length 3
    expect_cmd(8'h01, 16'd3, 32'h11);
    send_pkt(SLOT, 8'h01, 16'd3, 32'h11, 0);
    idle(20);

    // R1: junk then packet with zero-length payload
    put(32'h12345678); put(32'h5A5A5A5A); put(32'hDEADBEEF);
    expect_cmd(8'h02, 16'd0, 32'h22);
    send_pkt(SLOT, 8'h02, 16'd0, 32'h22, 0);
    idle(20);

    // R1: broken second preamble word, then repeated first word
    put(32'hA5A5A5A5); put(32'h00000000); put(32'hA5A5A5A5);
    expect_cmd(8'h03, 16'd2, 32'h33);
    send_pkt(SLOT, 8'h03, 16'd2, 32'h33, 0);
    idle(20);

    // R4: checksum corrupted
    expect_err(2'b10);
    send_pkt(SLOT, 8'h04, 16'd2, 32'h44, 1);
    idle(10);

    // R5: length 59 then unknown code
    expect_err(2'b01);
    send_pkt(SLOT, 8'h01, 16'd59, 32'h55, 0);
    idle(10);
    expect_err(2'b01);
    send_pkt(SLOT, 8'h09, 16'd2, 32'h66, 0);
    idle(10);

    // R5 boundary: length 58 accepted
    expect_cmd(8'h05, 16'd58, 32'h77);
    send_pkt(SLOT, 8'h05, 16'd58, 32'h77, 0);
    idle(80);

    // R6: foreign card, with bad code and with bad checksum: silent
    send_pkt(8'h08, 8'h09, 16'd1, 32'h88, 0);
    send_pkt(8'h08, 8'h01, 16'd1, 32'h89, 1);
    idle(5);
    check(q.size() == 0, "R6", "queue after foreign packets", 32'(q.size()), 32'h0);

    // R7: broadcast address
    expect_cmd(8'h02, 16'd4, 32'h99);
    send_pkt(8'hFF, 8'h02, 16'd4, 32'h99, 0);
    idle(20);

    // R8 R9: hold without ready, packet sent during hold is lost
    auto_ack = 0;
    expect_cmd(8'h03, 16'd1, 32'hAA);
    send_pkt(SLOT, 8'h03, 16'd1, 32'hAA, 0);
    idle(3);
    check(cmd_valid == 1'b1, "R8", "held cmd_valid", 32'(cmd_valid), 32'h1);
    send_pkt(SLOT, 8'h04, 16'd2, 32'hBB, 0);
    idle(2);
    check(cmd_valid == 1'b1 && cmd_code == 8'h03, "R9", "held code after drop",
          32'(cmd_code), 32'h03);
    check(cmd_len == 16'd1, "R8", "held cmd_len", 32'(cmd_len), 32'h1);
    auto_ack = 1;
    idle(10);
    expect_cmd(8'h01, 16'd2, 32'hCC);
    send_pkt(SLOT, 8'h01, 16'd2, 32'hCC, 0);
    idle(20);

    check(q.size() == 0, "R3", "expected events left over", 32'(q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule